// File: doc/BRIEF.md
# Folded Biquad Filter Bank

This block runs a bank of independent IIR filters on one shared second-order-section (biquad) datapath. With the default parameters there are 15 filters, and each is a cascade of 4 biquad sections. That makes 60 section slots. A sequencer gives one clock cycle to each slot. It walks the whole bank in a fixed frame of 60 cycles. In each slot it fetches that section's coefficients from a computed coefficient ROM. It reads the section's delay-line state from a single-port RAM and writes the updated state back at the end of the same cycle.

A source mux feeds the arithmetic unit. For a filter's first section it takes the freshly accepted sample. For every later section it takes the previous section's result, which is held in a feedback register. Samples enter on one shared valid/ready channel. The block names, on `in_chan`, the filter whose first slot is current, so each filter takes at most one sample per frame. That is the input's rate reduction against the faster section clock. Results leave on a valid/ready channel tagged with the filter number, at most one per filter per frame.

Back-pressure rules: `in_ready` is high for one cycle per filter per frame, and only when the block is running. A sample transfers on a cycle where `in_valid` and `in_ready` are both high. When an output is held (`out_valid` high, `out_ready` low), the whole sequencer freezes. The output word then stays unchanged and `in_ready` stays low until the consumer takes it.

Top module: `fold_iir_bank`

## Requirements
- R1: A synchronous reset clears the state of all 60 sections over 60 cycles. During those cycles `in_ready` and `out_valid` stay low. On the 60th cycle after reset is released, `in_ready` is high with `in_chan` = 0. After a reset, every filter responds as if all its past inputs and outputs were zero.
- R2: Each running (not stalled) cycle serves one slot, numbered filter·4 + section. Slot 59 wraps to slot 0. A filter's first slot therefore recurs every 60 running cycles, `in_ready` rises 4 running cycles after the previous filter's, and `in_ready` is high only in a first slot, with `in_chan` giving that filter.
- R3: A sample is accepted when `in_valid` and `in_ready` are both high. It becomes the input x of section 0 of filter `in_chan`.
- R4: In the same frame, sections 1 to 3 of that filter take the result of the section before them as their input.
- R5: Each section computes acc = b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2. Here x1 and x2 are the section's last two inputs and y1 and y2 its last two outputs. The result is acc shifted right arithmetically by 14 (a floor), then saturated.
- R6: The coefficients for filter f and section s, in signed Q2.14, are: b0 = 12288 + 1024·s, b1 = 8192 − 256·f, b2 = 4096, a1 = −8192 + 256·f, a2 = 2048 + 512·s.
- R7: A section result above 32767 becomes 32767, and one below −32768 becomes −32768. The saturated value is the one stored as state and passed to the next section.
- R8: For each accepted sample, exactly one output is produced once section 3 of that filter completes. It has `out_chan` = filter and `out_data` = section 3's result.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_chan` hold, `in_ready` stays low, and no section advances.
- R10: If a filter's first slot passes without a transfer, none of its sections run in that frame. Its state is unchanged and it produces no output.
- R11: Each section's state belongs to that section alone and is kept from one frame to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted this cycle if valid |
| in_data | input | 16 | Input sample, signed |
| in_chan | output | 4 | Filter whose first slot is current |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 16 | Filter result, signed |
| out_chan | output | 4 | Filter that produced the result |

## Verification
Several properties are checked on every cycle. The slot number must always equal filter·4 + section and must wrap from 59 to 0. Nothing may be accepted or emitted while the state is being cleared. A held output must stay frozen and block input, and the sequencer must not move during the hold. The arithmetic and the cascade can only be shown by the bench's scenarios, which compare each output against a reference model built from the coefficient and rounding rules. The same is true of saturation, of skipped filters leaving their state intact, of the counts of outputs against accepted samples, and of the clearing of state by a reset.

// File: rtl/fold_iir_pkg.sv
package fold_iir_pkg;

  typedef enum logic {
    SRC_INPUT    = 1'b0,
    SRC_FEEDBACK = 1'b1
  } src_e;

  // Coefficient set per (filter, section), signed Q2.14
  // k: 0=b0 1=b1 2=b2 3=a1 4=a2
  function automatic int coef_val(int f, int s, int k);
    case (k)
      0:       return 12288 + 1024 * s;
      1:       return 8192 - 256 * f;
      2:       return 4096;
      3:       return -8192 + 256 * f;
      default: return 2048 + 512 * s;
    endcase
  endfunction

endpackage

// File: rtl/fold_iir_coef_rom.sv
module fold_iir_coef_rom #(
  parameter int NF = 15,
  parameter int NS = 4,
  parameter int CW = 16,
  parameter int SW = 6
) (
  input  logic [SW-1:0]        addr,
  output logic signed [CW-1:0] b0,
  output logic signed [CW-1:0] b1,
  output logic signed [CW-1:0] b2,
  output logic signed [CW-1:0] a1,
  output logic signed [CW-1:0] a2
);
  localparam int SLOTS = NF * NS;

  logic signed [CW-1:0] t_b0 [SLOTS];
  logic signed [CW-1:0] t_b1 [SLOTS];
  logic signed [CW-1:0] t_b2 [SLOTS];
  logic signed [CW-1:0] t_a1 [SLOTS];
  logic signed [CW-1:0] t_a2 [SLOTS];

  for (genvar f = 0; f < NF; f++) begin : g_filt
    for (genvar s = 0; s < NS; s++) begin : g_sec
      localparam int IDX = f * NS + s;
      assign t_b0[IDX] = CW'(fold_iir_pkg::coef_val(f, s, 0));
      assign t_b1[IDX] = CW'(fold_iir_pkg::coef_val(f, s, 1));
      assign t_b2[IDX] = CW'(fold_iir_pkg::coef_val(f, s, 2));
      assign t_a1[IDX] = CW'(fold_iir_pkg::coef_val(f, s, 3));
      assign t_a2[IDX] = CW'(fold_iir_pkg::coef_val(f, s, 4));
    end
  end

  assign b0 = t_b0[addr];
  assign b1 = t_b1[addr];
  assign b2 = t_b2[addr];
  assign a1 = t_a1[addr];
  assign a2 = t_a2[addr];

endmodule

// File: rtl/fold_iir_state_ram.sv
module fold_iir_state_ram #(
  parameter int DEPTH = 60,
  parameter int WW    = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [WW-1:0] wdata,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] mem [DEPTH];

  // single port: read at the start of the slot, write back at its end
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/fold_iir_seq.sv
module fold_iir_seq
  import fold_iir_pkg::*;
#(
  parameter int NF = 15,
  parameter int NS = 4,
  parameter int SW = 6,
  parameter int FW = 4,
  parameter int NW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flow_en,
  input  logic          accept,
  output logic          clearing,
  output logic [SW-1:0] slot,
  output logic [FW-1:0] filt,
  output logic [NW-1:0] sec,
  output logic          first_slot,
  output logic          last_slot,
  output logic          act_now,
  output logic          ram_we,
  output logic [SW-1:0] ram_addr,
  output src_e          src_sel
);
  localparam int SLOTS = NF * NS;

  logic [SW-1:0] clr_cnt;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clearing <= 1'b1;
      clr_cnt  <= '0;
      slot     <= '0;
      filt     <= '0;
      sec      <= '0;
      act_q    <= 1'b0;
    end else if (clearing) begin
      clr_cnt <= clr_cnt + 1'b1;
      if (clr_cnt == SW'(SLOTS - 1)) clearing <= 1'b0;
    end else if (flow_en) begin
      act_q <= act_now;
      slot  <= (slot == SW'(SLOTS - 1)) ? '0 : slot + 1'b1;
      if (sec == NW'(NS - 1)) begin
        sec  <= '0;
        filt <= (filt == FW'(NF - 1)) ? '0 : filt + 1'b1;
      end else begin
        sec <= sec + 1'b1;
      end
    end
  end

  assign first_slot = (sec == '0);
  assign last_slot  = (sec == NW'(NS - 1));
  assign act_now    = first_slot ? accept : act_q;
  assign ram_we     = clearing | (flow_en & act_now);
  assign ram_addr   = clearing ? clr_cnt : slot;
  assign src_sel    = first_slot ? SRC_INPUT : SRC_FEEDBACK;

  // R2
  slot_map_chk: assert property (@(posedge clk) disable iff (rst)
    !clearing |-> (int'(slot) == int'(filt) * NS + int'(sec)));

  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clearing && flow_en && slot == SW'(SLOTS - 1)) |=> (slot == '0));

endmodule

// File: rtl/fold_iir_sos.sv
module fold_iir_sos
  import fold_iir_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14
) (
  input  src_e                 src_sel,
  input  logic signed [DW-1:0] in_sample,
  input  logic signed [DW-1:0] fb_sample,
  input  logic [4*DW-1:0]      st_rd,
  input  logic signed [CW-1:0] b0,
  input  logic signed [CW-1:0] b1,
  input  logic signed [CW-1:0] b2,
  input  logic signed [CW-1:0] a1,
  input  logic signed [CW-1:0] a2,
  output logic signed [DW-1:0] y,
  output logic [4*DW-1:0]      st_wr
);
  localparam int ACC_W = DW + CW + 3;

  logic signed [DW-1:0]    xin, x1, x2, y1, y2;
  logic signed [ACC_W-1:0] p0, p1, p2, p3, p4, acc, shf;
  logic                    ovf;

  assign xin = (src_sel == SRC_INPUT) ? in_sample : fb_sample;
  assign x1  = st_rd[4*DW-1 -: DW];
  assign x2  = st_rd[3*DW-1 -: DW];
  assign y1  = st_rd[2*DW-1 -: DW];
  assign y2  = st_rd[DW-1 -: DW];

  assign p0  = ACC_W'(b0) * ACC_W'(xin);
  assign p1  = ACC_W'(b1) * ACC_W'(x1);
  assign p2  = ACC_W'(b2) * ACC_W'(x2);
  assign p3  = ACC_W'(a1) * ACC_W'(y1);
  assign p4  = ACC_W'(a2) * ACC_W'(y2);
  assign acc = p0 + p1 + p2 - p3 - p4;
  assign shf = acc >>> FRAC;

  // overflow when the bits above the result sign differ from it
  assign ovf = (shf[ACC_W-1:DW-1] != {(ACC_W-DW+1){shf[DW-1]}});

  always_comb begin
    if (ovf) y = {shf[ACC_W-1], {(DW-1){~shf[ACC_W-1]}}};
    else     y = shf[DW-1:0];
  end

  assign st_wr = {xin, x1, y, y1};

endmodule

// File: rtl/fold_iir_bank.sv
module fold_iir_bank
  import fold_iir_pkg::*;
#(
  parameter int NF   = 15,
  parameter int NS   = 4,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int FW   = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic [FW-1:0] in_chan,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [FW-1:0] out_chan
);
  localparam int SLOTS = NF * NS;
  localparam int SW    = $clog2(SLOTS);
  localparam int NW    = (NS > 1) ? $clog2(NS) : 1;
  localparam int WW    = 4 * DW;

  logic                 clearing, flow_en, accept;
  logic [SW-1:0]        slot, ram_addr;
  logic [FW-1:0]        filt;
  logic [NW-1:0]        sec;
  logic                 first_slot, last_slot, act_now, ram_we;
  src_e                 src_sel;
  logic signed [CW-1:0] c_b0, c_b1, c_b2, c_a1, c_a2;
  logic [WW-1:0]        st_rd, st_wr, ram_wdata;
  logic signed [DW-1:0] y, fb_q;

  assign flow_en  = !clearing && !(out_valid && !out_ready);
  assign in_ready = flow_en && first_slot;
  assign in_chan  = filt;
  assign accept   = in_valid && in_ready;

  fold_iir_seq #(.NF(NF), .NS(NS), .SW(SW), .FW(FW), .NW(NW)) u_seq (
    .clk(clk), .rst(rst), .flow_en(flow_en), .accept(accept),
    .clearing(clearing), .slot(slot), .filt(filt), .sec(sec),
    .first_slot(first_slot), .last_slot(last_slot), .act_now(act_now),
    .ram_we(ram_we), .ram_addr(ram_addr), .src_sel(src_sel)
  );

  fold_iir_coef_rom #(.NF(NF), .NS(NS), .CW(CW), .SW(SW)) u_rom (
    .addr(slot), .b0(c_b0), .b1(c_b1), .b2(c_b2), .a1(c_a1), .a2(c_a2)
  );

  assign ram_wdata = clearing ? '0 : st_wr;

  fold_iir_state_ram #(.DEPTH(SLOTS), .WW(WW), .AW(SW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(st_rd)
  );

  fold_iir_sos #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_sos (
    .src_sel(src_sel), .in_sample(in_data), .fb_sample(fb_q), .st_rd(st_rd),
    .b0(c_b0), .b1(c_b1), .b2(c_b2), .a1(c_a1), .a2(c_a2),
    .y(y), .st_wr(st_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_q      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
    end else if (flow_en) begin
      if (act_now) fb_q <= y;
      out_valid <= act_now && last_slot;
      if (act_now && last_slot) begin
        out_data <= y;
        out_chan <= filt;
      end
    end
  end

  // R1
  no_io_in_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clearing |-> (!in_ready && !out_valid));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_chan)));

  // R9
  stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(slot) && !$past(in_ready)));

  // R8
  out_chan_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_chan) < NF));

endmodule

// File: tb/sim_fold_iir_bank.sv
module sim_fold_iir_bank;
  localparam int NF = 15;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [3:0]  in_chan;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic [3:0]  out_chan;

  always #2 clk = ~clk;

  fold_iir_bank u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_chan(in_chan), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_chan(out_chan)
  );

  int     n_chk = 0, n_fail = 0, cyc = 0;
  longint ms [NF][NS][4];
  longint exp_v [NF];
  bit     exp_p [NF];
  int     acc_cnt [NF];
  int     out_cnt [NF];
  bit     saw_hi, saw_lo;

  task automatic check(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R6 coefficients
  function automatic longint coefm(int f, int s, int k);
    case (k)
      0: return 12288 + 1024 * s;
      1: return 8192 - 256 * f;
      2: return 4096;
      3: return -8192 + 256 * f;
      default: return 2048 + 512 * s;
    endcase
  endfunction

  // R7 saturation
  function automatic longint satm(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // R4 R5 cascade reference
  function automatic longint model_run(int f, longint xin);
    longint x, acc, yv;
    x = xin;
    for (int s = 0; s < NS; s++) begin
      acc = coefm(f, s, 0) * x + coefm(f, s, 1) * ms[f][s][0]
          + coefm(f, s, 2) * ms[f][s][1] - coefm(f, s, 3) * ms[f][s][2]
          - coefm(f, s, 4) * ms[f][s][3];
      yv = satm(acc >>> 14);
      ms[f][s][1] = ms[f][s][0];
      ms[f][s][0] = x;
      ms[f][s][3] = ms[f][s][2];
      ms[f][s][2] = yv;
      x = yv;
    end
    return x;
  endfunction

  function automatic longint gen(int mode, int f, int k);
    case (mode)
      0: return (k == 0) ? 8192 : 0;
      1: return ((f * 1237 + k * 311 + 17) % 20001) - 10000;
      default: return (f % 2 == 0) ? 32767 : -32768;
    endcase
  endfunction

  task automatic model_clear();
    for (int f = 0; f < NF; f++) begin
      exp_p[f] = 0;
      for (int s = 0; s < NS; s++)
        for (int k = 0; k < 4; k++) ms[f][s][k] = 0;
    end
  endtask

  task automatic clr_counts();
    for (int f = 0; f < NF; f++) begin
      acc_cnt[f] = 0;
      out_cnt[f] = 0;
    end
  endtask

  // one cycle per iteration; drive and sample at the falling edge
  task automatic run(int n, int mask, int dmode, int rmode);
    bit          hold_prev = 0;
    logic [15:0] hold_data = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      out_ready = (rmode == 0) ? 1'b1 : (cyc % 3 != 0);
      #1;
      if (hold_prev) begin
        check(out_valid && out_data == hold_data, "R9 held output",
              longint'(out_data), longint'(hold_data));
      end
      if (out_valid && out_ready) begin
        int f = int'(out_chan);
        check(f < NF && exp_p[f], "R8 output without accepted sample", f, -1);
        if (f < NF) begin
          check($signed(out_data) == exp_v[f], "R5 filter result",
                longint'($signed(out_data)), exp_v[f]);
          if ($signed(out_data) == 16'sd32767) saw_hi = 1;
          if ($signed(out_data) == -16'sd32768) saw_lo = 1;
          exp_p[f] = 0;
          out_cnt[f]++;
        end
      end
      hold_prev = out_valid && !out_ready;
      hold_data = out_data;
      if (hold_prev) check(!in_ready, "R9 input blocked while held", in_ready, 0);
      if (in_ready && mask[in_chan]) begin
        int f = int'(in_chan);
        longint x = gen(dmode, f, acc_cnt[f]);
        in_valid = 1'b1;
        in_data  = 16'(x);
        exp_v[f] = model_run(f, x);
        exp_p[f] = 1;
        acc_cnt[f]++;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain_and_count(string req);
    int a = 0, o = 0;
    run(70, 0, 0, 0);
    for (int f = 0; f < NF; f++) begin
      a += acc_cnt[f];
      o += out_cnt[f];
    end
    check(a == o && a > 0, req, o, a);
  endtask

  task automatic t_reset();
    bit low_ok = 1;
    in_valid = 0;
    out_ready = 1;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model_clear();
    for (int k = 1; k < 60; k++) begin
      @(negedge clk);
      if (in_ready || out_valid) low_ok = 0;
    end
    check(low_ok, "R1 in_ready/out_valid low while clearing", !low_ok, 0);
    @(negedge clk);
    check(in_ready && in_chan == 0, "R1 ready on 60th cycle for filter 0",
          {in_ready, in_chan}, 5'h10);
    low_ok = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (in_ready) low_ok = 0;
    end
    check(low_ok, "R2 in_ready low outside first slots", !low_ok, 0);
    @(negedge clk);
    check(in_ready && in_chan == 1, "R2 next filter 4 cycles later",
          {in_ready, in_chan}, 5'h11);
  endtask

  task automatic t_impulse();
    clr_counts();
    run(480, 1 << 3, 0, 0);
    check(acc_cnt[3] == 8, "R2 one first slot per 60 cycles", acc_cnt[3], 8);
    run(70, 0, 0, 0);
    check(out_cnt[3] == 8, "R8 one output per sample", out_cnt[3], 8);
    check(out_cnt[2] == 0 && out_cnt[4] == 0, "R10 idle filters silent",
          out_cnt[2] + out_cnt[4], 0);
  endtask

  task automatic t_full();
    clr_counts();
    run(600, 16'h7fff, 1, 0);
    drain_and_count("R3 all filters accepted and answered");
  endtask

  task automatic t_skip();
    clr_counts();
    run(300, 16'h7fff & ~(1 << 5), 1, 0);
    run(70, 0, 0, 0);
    check(out_cnt[5] == 0 && acc_cnt[5] == 0, "R10 skipped filter no output",
          out_cnt[5], 0);
    clr_counts();
    run(180, 1 << 5, 1, 0);
    drain_and_count("R11 state kept across skipped frames");
  endtask

  task automatic t_stall();
    clr_counts();
    run(900, 16'h7fff, 1, 1);
    drain_and_count("R9 no sample lost under back-pressure");
  endtask

  task automatic t_sat();
    clr_counts();
    saw_hi = 0;
    saw_lo = 0;
    run(360, 16'h7fff, 2, 0);
    drain_and_count("R7 outputs under saturation");
    check(saw_hi && saw_lo, "R7 both rails reached", {saw_hi, saw_lo}, 3);
  endtask

  task automatic t_reset_clears();
    t_reset();
    clr_counts();
    run(480, 1 | (1 << 14), 0, 0);
    drain_and_count("R1 state cleared by reset");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    check(!out_valid, "R1 no output after reset", out_valid, 0);
    t_impulse();
    t_full();
    t_skip();
    t_stall();
    t_sat();
    t_reset_clears();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule